// File: doc/BRIEF.md
# Write-Busy Acknowledge Polling Slave

This block is the front end of a two-wire serial slave. It watches the clock and data lines and receives the address byte after each START. It then decides, on the ninth clock of that byte, whether to pull the data line low as an acknowledge. A write command is an acknowledged address with the direction bit low, followed by one or more data bytes, each of which the slave acknowledges. When a STOP ends such a command, the slave starts an internal programming interval. A cycle counter models that interval, and its length is a parameter.

While the interval runs, the slave refuses every command. A master that wants to know when the programming has finished sends only a START and the device address. It gets no acknowledge while the interval is still counting, and it gets an acknowledge as soon as the interval has expired. It can then carry on with the command that follows. The direction bit plays no part in this decision.

The two bus lines are sampled through synchronizers, so START and STOP are detected as a data-line edge while the clock line is high. The slave only ever pulls the data line low, through an open-drain enable. A one-cycle pulse marks the start of each programming interval, and a level output follows the interval itself.

Top module: `wbPollSlave`

## Requirements
- R1: A STOP that closes a write command in which the address was acknowledged and at least one full data byte was received raises `busyStart` for exactly one clock cycle. `busy` rises in the same cycle.
- R2: Each data byte of an accepted write is acknowledged: `sdaOe` is high while SCL is high on the ninth clock of the byte.
- R3: While `busy` is high, an address byte whose upper seven bits match `DEV_ADDR` is not acknowledged: `sdaOe` stays low through its ninth clock.
- R4: The address byte is sent most significant bit first. Its upper seven bits are the device address and bit 0 is the direction bit (0 = write, 1 = read). The direction bit does not change the acknowledge decision, whether the slave is busy or idle.
- R5: An address byte whose upper seven bits differ from `DEV_ADDR` is never acknowledged, busy or idle.
- R6: Once `busy` has fallen, a matching address is acknowledged and a following write is accepted and acknowledged.
- R7: `busy` stays high for exactly `BUSY_CYCLES` clock cycles after it rises.
- R8: A STOP that follows an acknowledged write address with no complete data byte does not start a programming interval.
- R9: A repeated START partway through an address byte discards the partial byte, and the address that follows is received and judged normally.
- R10: After reset, `sdaOe`, `busy` and `busyStart` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Serial clock line, as seen at the pin |
| sdaIn | input | 1 | Serial data line, as seen at the pin |
| sdaOe | output | 1 | Open-drain enable; high pulls the data line low |
| busyStart | output | 1 | One-cycle pulse when a programming interval begins |
| busy | output | 1 | High while the programming interval runs |

## Verification
The assertions check on every cycle that `busyStart` is a single-cycle pulse coinciding with the rise of `busy`, that each busy run lasts exactly `BUSY_CYCLES`, and that the slave never starts driving an acknowledge while busy. The bench's bus scenarios are needed for everything that depends on the content of the serial stream. These are address matching, the direction bit being ignored, polling going from NACK to ACK across the end of the interval, the rule that an address-only write starts nothing, and recovery from a repeated START inside a byte.

// File: rtl/wbPollPkg.sv
package wbPollPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_SKIP
  } pollState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrBits;
    logic shiftEn;
    logic ackOn;
    logic ackOff;
    logic loadBusy;
  } pollStrobes_t;

  // Events and status from datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
    logic byteFull;
    logic addrMatch;
    logic rwBit;
    logic busy;
  } pollEvents_t;

endpackage

// File: rtl/pollSync.sv
module pollSync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pollDatapath.sv
module pollDatapath
  import wbPollPkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         BUSY_CYCLES = 500000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         scl,
  input  logic         sdaIn,
  input  pollStrobes_t strobes,
  output pollEvents_t  events,
  output logic         sdaOe,
  output logic         busyStart,
  output logic         busy
);

  localparam int CNT_W  = $clog2(BUSY_CYCLES + 1);
  localparam int BITS_W = 4;
  localparam logic [BITS_W-1:0] BYTE_BITS = BITS_W'(8);
  localparam logic [CNT_W-1:0]  BUSY_LOAD = CNT_W'(BUSY_CYCLES);

  logic [1:0] rawLines;
  logic [1:0] syncLines;
  assign rawLines = {sdaIn, scl};

  // One synchronizer per bus line
  for (genvar g = 0; g < 2; g++) begin : gSync
    pollSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk (clk),
      .rstN(rstN),
      .d   (rawLines[g]),
      .q   (syncLines[g])
    );
  end

  logic sclNow, sdaNow, sclPrev, sdaPrev;
  assign sclNow = syncLines[0];
  assign sdaNow = syncLines[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  logic [BITS_W-1:0] bitCnt;
  logic [7:0]        shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (strobes.clrBits) begin
      bitCnt <= '0;
    end else if (strobes.shiftEn) begin
      shiftReg <= {shiftReg[6:0], sdaNow};
      bitCnt   <= bitCnt + 1'b1;
    end
  end

  logic ackDrive;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ackDrive <= 1'b0;
    else if (strobes.ackOff) ackDrive <= 1'b0;
    else if (strobes.ackOn)  ackDrive <= 1'b1;
  end

  logic [CNT_W-1:0] busyCnt;
  logic             startQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
      startQ  <= 1'b0;
    end else begin
      startQ <= strobes.loadBusy;
      if (strobes.loadBusy)   busyCnt <= BUSY_LOAD;
      else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
    end
  end

  always_comb begin
    events.sclRise   = sclNow & ~sclPrev;
    events.sclFall   = ~sclNow & sclPrev;
    events.startDet  = sclNow & sclPrev & sdaPrev & ~sdaNow;
    events.stopDet   = sclNow & sclPrev & ~sdaPrev & sdaNow;
    events.byteFull  = (bitCnt == BYTE_BITS);
    events.addrMatch = (shiftReg[7:1] == DEV_ADDR);
    events.rwBit     = shiftReg[0];
    events.busy      = (busyCnt != '0);
  end

  assign sdaOe     = ackDrive;
  assign busyStart = startQ;
  assign busy      = (busyCnt != '0);

endmodule

// File: rtl/pollCtrl.sv
module pollCtrl
  import wbPollPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  pollEvents_t  events,
  output pollStrobes_t strobes
);

  pollState_t state, stateNext;
  logic       dataSeen, dataSeenNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      dataSeen <= 1'b0;
    end else begin
      state    <= stateNext;
      dataSeen <= dataSeenNext;
    end
  end

  always_comb begin
    stateNext    = state;
    dataSeenNext = dataSeen;
    strobes      = '0;
    if (events.startDet) begin
      stateNext       = ST_ADDR;
      strobes.clrBits = 1'b1;
      strobes.ackOff  = 1'b1;
      dataSeenNext    = 1'b0;
    end else if (events.stopDet) begin
      stateNext        = ST_IDLE;
      strobes.clrBits  = 1'b1;
      strobes.ackOff   = 1'b1;
      strobes.loadBusy = dataSeen;
      dataSeenNext     = 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_DATA: begin
          if (events.sclRise && !events.byteFull) begin
            strobes.shiftEn = 1'b1;
          end
          if (events.sclFall && events.byteFull) begin
            if (state == ST_DATA) begin
              strobes.ackOn = 1'b1;
              stateNext     = ST_DATA_ACK;
            end else if (events.addrMatch && !events.busy) begin
              strobes.ackOn = 1'b1;
              stateNext     = ST_ADDR_ACK;
            end else begin
              stateNext = ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (events.sclFall) begin
            strobes.ackOff  = 1'b1;
            strobes.clrBits = 1'b1;
            stateNext       = events.rwBit ? ST_SKIP : ST_DATA;
          end
        end
        ST_DATA_ACK: begin
          if (events.sclFall) begin
            strobes.ackOff  = 1'b1;
            strobes.clrBits = 1'b1;
            dataSeenNext    = 1'b1;
            stateNext       = ST_DATA;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/wbPollSlave.sv
module wbPollSlave
  import wbPollPkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         BUSY_CYCLES = 500000
) (
  input  logic clk,
  input  logic rstN,
  input  logic scl,
  input  logic sdaIn,
  output logic sdaOe,
  output logic busyStart,
  output logic busy
);

  pollStrobes_t strobes;
  pollEvents_t  events;

  pollCtrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .events (events),
    .strobes(strobes)
  );

  pollDatapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .DEV_ADDR   (DEV_ADDR),
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .scl      (scl),
    .sdaIn    (sdaIn),
    .strobes  (strobes),
    .events   (events),
    .sdaOe    (sdaOe),
    .busyStart(busyStart),
    .busy     (busy)
  );

endmodule

// File: rtl/wbPollSlaveChk.sv
module wbPollSlaveChk #(
  parameter int BUSY_CYCLES = 500000
) (
  input logic clk,
  input logic rstN,
  input logic sdaOe,
  input logic busyStart,
  input logic busy
);

  int runLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     runLen <= 0;
    else if (busy) runLen <= runLen + 1;
    else           runLen <= 0;
  end

  // R1: pulse lasts one cycle
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    busyStart |=> !busyStart);

  // R1: pulse coincides with the rise of busy
  a_r1_busy_rises: assert property (@(posedge clk) disable iff (!rstN)
    busyStart |-> $rose(busy));

  // R7: each busy run has the configured length
  a_r7_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == BUSY_CYCLES));

  // R3: no acknowledge is started while busy
  a_r3_no_ack_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !busy);

  // R10: reset state
  always @(posedge clk) begin
    if (!rstN) begin
      a_r10_reset_quiet: assert (!busyStart);
    end
  end

endmodule

bind wbPollSlave wbPollSlaveChk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sdaOe    (sdaOe),
  .busyStart(busyStart),
  .busy     (busy)
);

// File: tb/wbPollSlave_bench.sv
`timescale 1ns/1ps
module wbPollSlave_bench;

  localparam int         BUSY = 2000;
  localparam int         QTR  = 10;
  localparam logic [6:0] DEV  = 7'h2A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe, busyStart, busy;
  logic sdaLine;

  assign sdaLine = sdaM & ~sdaOe;

  always #5 clk = ~clk;

  wbPollSlave #(.SYNC_STAGES(2), .DEV_ADDR(DEV), .BUSY_CYCLES(BUSY)) u_wbPollSlave (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .busyStart(busyStart), .busy(busy)
  );

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  int busyCycles = 0;

  always @(negedge clk) begin
    if (busyStart) pulses++;
    if (busy) busyCycles++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ();
    scl  = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    scl  = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ();
    scl  = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; waitQ();
      scl  = 1'b1; waitQ(); waitQ();
      scl  = 1'b0; waitQ();
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    sendBits(b, 8);
    sdaM = 1'b1; waitQ();
    scl  = 1'b1; waitQ();
    acked = (sdaLine == 1'b0) && sdaOe;
    waitQ();
    scl  = 1'b0; waitQ();
  endtask

  // {address byte, expected acknowledge} with the slave idle
  localparam logic [8:0] VEC [6] = '{
    {8'h54, 1'b1},
    {8'h55, 1'b1},
    {8'h56, 1'b0},
    {8'hAA, 1'b0},
    {8'h00, 1'b0},
    {8'h55, 1'b1}
  };

  initial begin
    repeat (150000) @(negedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit ack;
    int polls;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!sdaOe && !busy && !busyStart, "R10", {sdaOe, busy, busyStart}, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // Vector table: idle slave, R4/R5/R8
    foreach (VEC[k]) begin
      busStart();
      sendByte(VEC[k][8:1], ack);
      check(ack == VEC[k][0], VEC[k][0] ? "R4" : "R5", ack, VEC[k][0]);
      busStop();
      repeat (5) @(negedge clk);
      check(!busy && pulses == 0, "R8", pulses, 0);
    end

    // R1/R2: full write starts busy
    busyCycles = 0;
    busStart();
    sendByte(8'h54, ack);
    check(ack, "R6", ack, 1);
    sendByte(8'h3C, ack);
    check(ack, "R2", ack, 1);
    busStop();
    repeat (5) @(negedge clk);
    check(pulses == 1, "R1", pulses, 1);
    check(busy, "R1", busy, 1);

    // R3/R4: polling while busy
    busStart();
    sendByte(8'h54, ack);
    check(!ack, "R3", ack, 0);
    busStop();
    busStart();
    sendByte(8'h55, ack);
    check(!ack, "R4", ack, 0);
    busStop();
    busStart();
    sendByte(8'h56, ack);
    check(!ack, "R5", ack, 0);
    busStop();
    check(busy && pulses == 1, "R3", pulses, 1);

    // R6: poll until acknowledged, then continue a write
    polls = 0;
    ack = 1'b0;
    while (!ack && polls < 40) begin
      busStart();
      sendByte(8'h54, ack);
      polls++;
      if (!ack) busStop();
    end
    check(ack && !busy, "R6", ack, 1);
    check(busyCycles == BUSY, "R7", busyCycles, BUSY);
    sendByte(8'hA5, ack);
    check(ack, "R6", ack, 1);
    sendByte(8'h0F, ack);
    check(ack, "R2", ack, 1);
    busStop();
    repeat (5) @(negedge clk);
    check(pulses == 2 && busy, "R1", pulses, 2);

    // Wait out the interval
    while (busy) @(negedge clk);
    repeat (5) @(negedge clk);

    // R9: repeated START inside an address byte
    busStart();
    sendBits(8'hF0, 4);
    busStart();
    sendByte(8'h54, ack);
    check(ack, "R9", ack, 1);
    busStop();
    busStart();
    sendBits(8'h54, 5);
    busStart();
    sendByte(8'h80, ack);
    check(!ack, "R9", ack, 0);
    busStop();
    repeat (5) @(negedge clk);
    check(pulses == 2 && !busy, "R8", pulses, 2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule